// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A controller or a memory model gives it a start column with a read or write strobe, together with the programmed burst length and burst ordering. The block presents the first column in the same cycle as the command. This lets write data for beat zero be captured with the command. It then steps through the rest of the burst on each following clock, and it flags the final beat.

A read or write that arrives while a burst is still running drops the unfinished beats. It starts a fresh burst of the full programmed length at the new column, so a new column command can be taken on every clock. The page-length setting runs without end, wrapping around the page, until a stop command or a new command ends it. A stop during a fixed-length burst is reported as a protocol error and does not change the burst. An unsupported length code is also reported as an error and gives a single beat.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is held and after it is released with no command, beat_valid, burst_last, mode_err and stop_err are all 0.
- R2: A command with cmd_valid=1 and cmd_op of 1 (read) or 2 (write) produces a beat in the same cycle with col_out equal to start_col, and beat_is_write is 1 for a write and 0 for a read on every beat of that burst (cmd_op 0 means no command, 3 means stop).
- R3: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats on consecutive cycles. burst_last is 1 only on the final beat, and no beat follows it until the next command.
- R4: With ilv_mode=0 and a fixed length L, beat k addresses the start column with its low log2(L) bits replaced by (start_col + k) mod L, so the upper bits never change within the burst.
- R5: With ilv_mode=1 and a fixed length L, beat k addresses start_col XOR k.
- R6: Length code 7 selects a page burst. Beat k addresses (start_col + k) mod 2^COL_W whatever ilv_mode is, burst_last stays 0, and the burst continues past the end of the page.
- R7: A read or write arriving during a burst replaces the remaining beats with a new burst of the full length at the new start column, beginning in that same cycle.
- R8: A stop command (cmd_op 3) during a page burst produces no beat in its own cycle and ends the burst, so no further beats follow.
- R9: A stop command during a fixed-length burst raises stop_err for that cycle and leaves the burst's columns and length unchanged. A stop with no burst running has no effect and no error.
- R10: Length codes 4, 5 and 6 are unsupported. Such a command raises mode_err in its own cycle and gives exactly one beat at start_col, with burst_last set.
- R11: Commands on consecutive cycles are each accepted, and each one produces its own first beat in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe for this cycle |
| cmd_op | input | 2 | 0 none, 1 read, 2 write, 3 stop |
| start_col | input | COL_W | Starting column of a read or write |
| blen_code | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 7 gives a page burst |
| ilv_mode | input | 1 | 1 selects interleaved order for fixed lengths |
| col_out | output | COL_W | Column for the current beat |
| beat_valid | output | 1 | A beat is issued this cycle |
| burst_last | output | 1 | The current beat is the final one of its burst |
| beat_is_write | output | 1 | The current beat belongs to a write burst |
| mode_err | output | 1 | The command in this cycle used an unsupported length code |
| stop_err | output | 1 | A stop arrived during a fixed-length burst |

## Verification
A corrupted beat counter or held base column shows up at col_out on the very next beat. Within a fixed burst it either moves the upper column bits out of the aligned block or breaks the XOR pattern. In a page burst it breaks the step of one. A wrong held length or active bit shows up within at most eight cycles, as a missing or early burst_last, or as beats that continue after the final one or after a stop. A first beat that is held in a register instead of passed through shows up at once, because col_out then differs from start_col in the command cycle.

// File: rtl/colgen_pkg.sv
`timescale 1ns/1ps
package colgen_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_STOP  = 2'd3
  } col_op_e;

  localparam logic [2:0] BLC_PAGE = 3'd7;

  typedef struct packed {
    logic       legal;
    logic       page;
    logic [1:0] lg;
  } blen_info_t;

endpackage

// File: rtl/colgen_mode_decode.sv
`timescale 1ns/1ps
module colgen_mode_decode
  import colgen_pkg::*;
(
  input  logic [2:0] blen_code,
  output blen_info_t info
);

  always_comb begin
    info = '0;
    if (blen_code == BLC_PAGE) begin
      info.legal = 1'b1;
      info.page  = 1'b1;
    end else if (blen_code[2] == 1'b0) begin
      info.legal = 1'b1;
      info.lg    = blen_code[1:0];
    end
  end

endmodule

// File: rtl/colgen_addr.sv
`timescale 1ns/1ps
module colgen_addr #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0] b,
    input logic [COL_W-1:0] k,
    input logic [COL_W-1:0] m,
    input logic             x
  );
    logic [COL_W-1:0] sum;
    sum = b + k;
    if (x) return b ^ (k & m);
    return (b & ~m) | (sum & m);
  endfunction

  assign col = beat_col(base, beat, mask, ilv);

endmodule

// File: rtl/colgen_seq.sv
`timescale 1ns/1ps
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] start_col,
  input  blen_info_t       info,
  input  logic             ilv_in,
  output logic [COL_W-1:0] cur_base,
  output logic [COL_W-1:0] cur_beat,
  output logic [COL_W-1:0] cur_mask,
  output logic             cur_ilv,
  output logic             beat_valid,
  output logic             burst_last,
  output logic             beat_is_write,
  output logic             mode_err,
  output logic             stop_err,
  output logic             new_burst,
  output logic             cont_beat,
  output logic             stop_hit,
  output logic             page_cur
);

  function automatic logic [COL_W-1:0] mask_of(input logic [1:0] lg, input logic page);
    if (page) return {COL_W{1'b1}};
    return ~({COL_W{1'b1}} << lg);
  endfunction

  logic             act_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt_q;
  logic [1:0]       lg_q;
  logic             page_q;
  logic             ilv_q;
  logic             wr_q;

  logic             is_rw;
  logic             is_stop;
  logic [COL_W-1:0] new_mask;
  logic [COL_W-1:0] held_mask;

  assign is_rw     = cmd_valid && (cmd_op == OP_READ || cmd_op == OP_WRITE);
  assign is_stop   = cmd_valid && (cmd_op == OP_STOP);
  assign stop_hit  = is_stop && act_q && page_q;
  assign stop_err  = is_stop && act_q && !page_q;
  assign mode_err  = is_rw && !info.legal;
  assign new_burst = is_rw;
  assign new_mask  = mask_of(info.lg, info.page);
  assign held_mask = mask_of(lg_q, page_q);

  always_comb begin
    cur_base      = base_q;
    cur_beat      = cnt_q;
    cur_mask      = held_mask;
    cur_ilv       = ilv_q;
    page_cur      = page_q;
    beat_is_write = 1'b0;
    beat_valid    = 1'b0;
    burst_last    = 1'b0;
    if (is_rw) begin
      cur_base      = start_col;
      cur_beat      = '0;
      cur_mask      = new_mask;
      cur_ilv       = ilv_in && !info.page;
      page_cur      = info.page;
      beat_is_write = (cmd_op == OP_WRITE);
      beat_valid    = 1'b1;
      burst_last    = !info.page && (info.lg == 2'd0);
    end else if (act_q && !stop_hit) begin
      beat_is_write = wr_q;
      beat_valid    = 1'b1;
      burst_last    = !page_q && (cnt_q == held_mask);
    end
  end

  assign cont_beat = beat_valid && !is_rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      lg_q   <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
      wr_q   <= 1'b0;
    end else if (is_rw) begin
      act_q  <= !burst_last;
      base_q <= start_col;
      cnt_q  <= COL_W'(1);
      lg_q   <= info.lg;
      page_q <= info.page;
      ilv_q  <= ilv_in && !info.page;
      wr_q   <= (cmd_op == OP_WRITE);
    end else if (stop_hit) begin
      act_q <= 1'b0;
    end else if (act_q) begin
      act_q <= !burst_last;
      cnt_q <= cnt_q + COL_W'(1);
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
`timescale 1ns/1ps
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       blen_code,
  input  logic             ilv_mode,
  output logic [COL_W-1:0] col_out,
  output logic             beat_valid,
  output logic             burst_last,
  output logic             beat_is_write,
  output logic             mode_err,
  output logic             stop_err
);

  blen_info_t       info;
  logic [COL_W-1:0] cur_base;
  logic [COL_W-1:0] cur_beat;
  logic [COL_W-1:0] cur_mask;
  logic             cur_ilv;
  logic             new_burst;
  logic             cont_beat;
  logic             stop_hit;
  logic             page_cur;

  colgen_mode_decode u_dec (
    .blen_code (blen_code),
    .info      (info)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .start_col     (start_col),
    .info          (info),
    .ilv_in        (ilv_mode),
    .cur_base      (cur_base),
    .cur_beat      (cur_beat),
    .cur_mask      (cur_mask),
    .cur_ilv       (cur_ilv),
    .beat_valid    (beat_valid),
    .burst_last    (burst_last),
    .beat_is_write (beat_is_write),
    .mode_err      (mode_err),
    .stop_err      (stop_err),
    .new_burst     (new_burst),
    .cont_beat     (cont_beat),
    .stop_hit      (stop_hit),
    .page_cur      (page_cur)
  );

  colgen_addr #(.COL_W(COL_W)) u_addr (
    .base (cur_base),
    .beat (cur_beat),
    .mask (cur_mask),
    .ilv  (cur_ilv),
    .col  (col_out)
  );

endmodule

// File: rtl/colgen_checker.sv
`timescale 1ns/1ps
module colgen_checker #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [COL_W-1:0] start_col,
  input logic [2:0]       blen_code,
  input logic [COL_W-1:0] col_out,
  input logic             beat_valid,
  input logic             burst_last,
  input logic             mode_err,
  input logic             stop_err,
  input logic             new_burst,
  input logic             cont_beat,
  input logic             stop_hit,
  input logic             page_cur
);

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    new_burst |-> (beat_valid && col_out == start_col));

  p_single_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (new_burst && blen_code == 3'd0) |=> (!beat_valid || new_burst));

  p_last_has_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |-> beat_valid);

  p_block_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_beat && !page_cur) |-> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_beat && page_cur) |-> (col_out == COL_W'($past(col_out) + 1'b1)));

  p_page_no_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && page_cur) |-> !burst_last);

  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |-> !beat_valid);

  p_stop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_hit |=> (!beat_valid || new_burst));

  p_stop_err_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_err |-> (beat_valid && !page_cur));

  p_bad_mode_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (beat_valid && burst_last));

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_col  (start_col),
  .blen_code  (blen_code),
  .col_out    (col_out),
  .beat_valid (beat_valid),
  .burst_last (burst_last),
  .mode_err   (mode_err),
  .stop_err   (stop_err),
  .new_burst  (new_burst),
  .cont_beat  (cont_beat),
  .stop_hit   (stop_hit),
  .page_cur   (page_cur)
);

// File: tb/tb_sdram_burst_colgen.sv
`timescale 1ns/1ps
module tb_sdram_burst_colgen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] start_col = 8'd0;
  logic [2:0] blen_code = 3'd0;
  logic       ilv_mode = 1'b0;
  logic [7:0] col_out;
  logic       beat_valid, burst_last, beat_is_write, mode_err, stop_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_burst_colgen #(.COL_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .start_col(start_col), .blen_code(blen_code), .ilv_mode(ilv_mode),
    .col_out(col_out), .beat_valid(beat_valid), .burst_last(burst_last),
    .beat_is_write(beat_is_write), .mode_err(mode_err), .stop_err(stop_err)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] st;
    logic [2:0] bl;
    logic       il;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd1, 8'h00, 3'd0, 1'b0},
    '{2'd2, 8'h13, 3'd1, 1'b0},
    '{2'd1, 8'h26, 3'd2, 1'b0},
    '{2'd1, 8'h2D, 3'd3, 1'b0},
    '{2'd2, 8'h26, 3'd2, 1'b1},
    '{2'd1, 8'h55, 3'd3, 1'b1},
    '{2'd1, 8'h0A, 3'd1, 1'b1},
    '{2'd1, 8'hF1, 3'd3, 1'b1},
    '{2'd2, 8'h3C, 3'd5, 1'b0}
  };

  function automatic logic [7:0] exp_col(logic [7:0] s, int k, int len, bit il, bit page);
    int lo;
    if (page) return 8'((int'(s) + k) % 256);
    if (il) return s ^ 8'(k);
    lo = (int'(s) % len + k) % len;
    return 8'(int'(s) - int'(s) % len + lo);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [1:0] op, logic [7:0] s, logic [2:0] bl, logic il);
    @(negedge clk);
    cmd_valid = v; cmd_op = op; start_col = s; blen_code = bl; ilv_mode = il;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 8'h00, blen_code, ilv_mode);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 during and after reset
    repeat (3) @(negedge clk);
    #1;
    check("R1 valid in reset", beat_valid, 0);
    check("R1 flags in reset", {burst_last, mode_err, stop_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle();
    check("R1 idle after reset", {beat_valid, burst_last, mode_err, stop_err}, 0);

    // table of single bursts: R2 R3 R4 R5 R10
    foreach (VECS[i]) begin
      automatic vec_t v = VECS[i];
      automatic bit legal = (v.bl <= 3'd3);
      automatic int len = legal ? (1 << v.bl) : 1;
      drive(1'b1, v.op, v.st, v.bl, v.il);
      check("R2 first col", col_out, v.st);
      check("R10 mode_err", mode_err, !legal);
      for (int k = 0; k < len; k++) begin
        if (k > 0) idle();
        check(v.il ? "R5 col" : "R4 col", col_out, exp_col(v.st, k, len, v.il, 1'b0));
        check("R3 valid/last", {beat_valid, burst_last}, {1'b1, k == len - 1});
        check("R2 write flag", beat_is_write, v.op == 2'd2);
      end
      idle();
      check("R3 no beat after last", beat_valid, 0);
    end

    // R6 page burst wraps, ilv ignored, then R8 stop
    drive(1'b1, 2'd1, 8'hF8, 3'd7, 1'b1);
    for (int k = 0; k < 300; k++) begin
      if (k > 0) idle();
      check("R6 page col", col_out, exp_col(8'hF8, k, 256, 1'b0, 1'b1));
      check("R6 page valid no last", {beat_valid, burst_last}, 2'b10);
    end
    drive(1'b1, 2'd3, 8'h00, 3'd7, 1'b0);
    check("R8 no beat in stop cycle", {beat_valid, stop_err}, 0);
    idle();
    check("R8 no beat after stop", beat_valid, 0);

    // R9 stop in fixed burst ignored with error; idle stop no effect
    drive(1'b1, 2'd1, 8'h10, 3'd3, 1'b0);
    idle();
    drive(1'b1, 2'd3, 8'h00, 3'd3, 1'b0);
    check("R9 stop_err", stop_err, 1);
    check("R9 burst continues", col_out, 8'h12);
    for (int k = 3; k < 8; k++) begin
      idle();
      check("R9 col after bad stop", col_out, 8'h10 + 8'(k));
      check("R9 last after bad stop", burst_last, k == 7);
    end
    drive(1'b1, 2'd3, 8'h00, 3'd3, 1'b0);
    check("R9 idle stop", {beat_valid, stop_err}, 0);

    // R7 interrupt
    drive(1'b1, 2'd1, 8'h05, 3'd3, 1'b0);
    idle();
    check("R7 before interrupt", col_out, 8'h06);
    drive(1'b1, 2'd2, 8'h40, 3'd2, 1'b0);
    for (int k = 0; k < 4; k++) begin
      if (k > 0) idle();
      check("R7 new col", col_out, 8'h40 + 8'(k));
      check("R7 last", burst_last, k == 3);
      check("R7 write", beat_is_write, 1);
    end
    idle();
    check("R7 ends", beat_valid, 0);

    // R11 back-to-back
    drive(1'b1, 2'd1, 8'h80, 3'd2, 1'b0);
    check("R11 cmd0", col_out, 8'h80);
    drive(1'b1, 2'd1, 8'h91, 3'd2, 1'b0);
    check("R11 cmd1", col_out, 8'h91);
    drive(1'b1, 2'd1, 8'hA2, 3'd2, 1'b0);
    check("R11 cmd2", col_out, 8'hA2);
    for (int k = 1; k < 4; k++) begin
      idle();
      check("R11 tail", col_out, exp_col(8'hA2, k, 4, 1'b0, 1'b0));
    end
    idle();
    check("R11 ends", beat_valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule